// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This unit produces a reciprocal estimate accurate to about 8 bits for a single-precision IEEE-754 operand. It is meant as the seed for an iterative divide or reciprocal sequence. It also has an unsigned 32-bit fixed-point mode that uses the same estimate core. The core is computed arithmetically from a 9-bit normalised input, so there is no lookup table.

The unit decodes the operand's special classes first: NaNs, infinities, zeros, tiny values whose reciprocal would overflow, and large values that flush to zero. It then normalises subnormal operands, forms the result exponent, and denormalises the result when that exponent falls to 0 or -1. One operand is accepted per cycle, marked by `in_valid`. The result word and five exception flag pulses are registered and appear one cycle later, qualified by `out_valid`.

Top module: `recip_est`

## Requirements
- R1: `out_valid` rises in the cycle after every `in_valid` cycle and is low otherwise. All five flag outputs are low whenever `out_valid` is low.
- R2: With `fixed_mode`=1 and operand bit 31 set, let x = operand[31:23] (range 256..511). The result is {e, 23'b0}, where e = (floor(2^19 / (2x+1)) + 1) >> 1, which lies in 256..511.
- R3: With `fixed_mode`=1 and operand bit 31 clear, the result is 0xFFFFFFFF. Fixed mode never raises a flag.
- R4: Float mode, NaN input (exponent 255, fraction nonzero). If fraction bit 22 is clear, the input is signalling: invalid is raised and the input is returned with bit 22 set. A quiet NaN is returned unchanged with no flag. With `dnan`=1, any NaN returns 0x7FC00000.
- R5: Float mode. An infinite input returns zero of the same sign with no flags. A zero input returns infinity of the same sign and raises divide-by-zero.
- R6: Float mode, exponent 0, fraction below 2^21, `ftz`=0. Overflow and inexact are raised. The result is signed infinity when `rmode` is 00 (nearest), 01 (toward +inf) with a positive operand, or 10 (toward -inf) with a negative operand. Otherwise, including `rmode` 11 (toward zero), it is the signed maximum normal (magnitude 0x7F7FFFFF).
- R7: Float mode, `ftz`=1, biased exponent 253 or 254: underflow is raised and the result is signed zero.
- R8: Float mode, `ftz`=1: a subnormal input is treated as zero of its sign (signed infinity, divide-by-zero).
- R9: Float mode, normal input with exponent E that reaches the estimate path. The result keeps the input sign and has exponent field 253-E. Its fraction is e[7:0] followed by 15 zero bits, where e is the R2 estimate of {1, fraction[22:15]}.
- R10: When the result exponent 253-E is 0, the result has exponent field 0 and fraction {1, e[7:0], 14'b0}. When it is -1, the fraction is {01, e[7:0], 13'b0}. No flag is raised in either case.
- R11: With `ftz`=0, a subnormal input with fraction bit 22 set uses E=0 and estimate input {1, fraction[21:14]}. One with bit 22 clear and bit 21 set uses E=-1 and estimate input {1, fraction[20:13]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand valid this cycle |
| operand | input | 32 | Float or fixed-point operand |
| fixed_mode | input | 1 | 1 selects unsigned fixed-point mode |
| rmode | input | 2 | Rounding mode: 00 nearest, 01 +inf, 10 -inf, 11 zero |
| ftz | input | 1 | Flush subnormals and underflowing results to zero |
| dnan | input | 1 | Return the default NaN for any NaN input |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Estimate result |
| flg_invalid | output | 1 | Invalid-operation pulse |
| flg_divzero | output | 1 | Divide-by-zero pulse |
| flg_overflow | output | 1 | Overflow pulse |
| flg_underflow | output | 1 | Underflow pulse |
| flg_inexact | output | 1 | Inexact pulse |

## Verification
Every result and flag is due exactly one clock after the cycle in which its operand is presented with `in_valid`, because the path has a single register stage. The bench drives each operand on a falling edge and samples the outputs on the next falling edge. That is half a cycle after the capturing rising edge, and it is also when the next operand is driven, so operands stream back to back. A final idle cycle checks that `out_valid` and the flags drop one clock after `in_valid` does.

// File: rtl/recip_est.sv
module recip_est (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] operand,
  input  logic        fixed_mode,
  input  logic [1:0]  rmode,
  input  logic        ftz,
  input  logic        dnan,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flg_invalid,
  output logic        flg_divzero,
  output logic        flg_overflow,
  output logic        flg_underflow,
  output logic        flg_inexact
);
  localparam logic [7:0]  EXP_MAX  = 8'hFF;
  localparam logic [7:0]  EXP_FLUSH = 8'd253;
  localparam logic [31:0] QNAN_DEF = 32'h7FC00000;
  localparam logic [30:0] MAX_NORM = 31'h7F7FFFFF;

  function automatic logic [8:0] est9(input logic [8:0] x);
    logic [19:0] den, quo, rnd;
    den = {10'd0, x, 1'b1};
    quo = 20'h80000 / den;
    rnd = (quo + 20'd1) >> 1;
    return rnd[8:0];
  endfunction

  wire        sgn = operand[31];
  wire [7:0]  ex  = operand[30:23];
  wire [22:0] fr  = operand[22:0];

  wire is_nan   = (ex == EXP_MAX) && (fr != 23'd0);
  wire is_inf   = (ex == EXP_MAX) && (fr == 23'd0);
  wire is_zero  = (ex == 8'd0) && ((fr == 23'd0) || ftz);
  wire is_tiny  = (ex == 8'd0) && (fr[22:21] == 2'b00);
  wire is_big   = ftz && (ex >= EXP_FLUSH);
  wire to_inf   = (rmode == 2'b00) || (rmode == 2'b01 && !sgn) || (rmode == 2'b10 && sgn);

  logic [7:0]        top8;
  logic signed [9:0] eff_exp, rexp;
  logic [8:0]        est_f, est_x;
  logic [31:0]       n_res;
  logic [4:0]        n_flg;

  always_comb begin
    if (ex != 8'd0) begin
      top8    = fr[22:15];
      eff_exp = signed'({2'b00, ex});
    end else if (fr[22]) begin
      top8    = fr[21:14];
      eff_exp = 10'sd0;
    end else begin
      top8    = fr[20:13];
      eff_exp = -10'sd1;
    end
    rexp  = 10'sd253 - eff_exp;
    est_f = est9({1'b1, top8});
    est_x = est9(operand[31:23]);
  end

  always_comb begin
    n_flg = 5'b00000;
    if (fixed_mode) begin
      n_res = operand[31] ? {est_x, 23'd0} : 32'hFFFFFFFF;
    end else if (is_nan) begin
      n_flg[0] = !fr[22];
      n_res    = dnan ? QNAN_DEF : (operand | 32'h00400000);
    end else if (is_inf) begin
      n_res = {sgn, 31'd0};
    end else if (is_zero) begin
      n_flg[1] = 1'b1;
      n_res    = {sgn, EXP_MAX, 23'd0};
    end else if (is_tiny) begin
      n_flg[2] = 1'b1;
      n_flg[4] = 1'b1;
      n_res    = to_inf ? {sgn, EXP_MAX, 23'd0} : {sgn, MAX_NORM};
    end else if (is_big) begin
      n_flg[3] = 1'b1;
      n_res    = {sgn, 31'd0};
    end else if (rexp == 10'sd0) begin
      n_res = {sgn, 8'd0, 1'b1, est_f[7:0], 14'd0};
    end else if (rexp == -10'sd1) begin
      n_res = {sgn, 8'd0, 2'b01, est_f[7:0], 13'd0};
    end else begin
      n_res = {sgn, rexp[7:0], est_f[7:0], 15'd0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      result        <= 32'd0;
      flg_invalid   <= 1'b0;
      flg_divzero   <= 1'b0;
      flg_overflow  <= 1'b0;
      flg_underflow <= 1'b0;
      flg_inexact   <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      flg_invalid   <= in_valid & n_flg[0];
      flg_divzero   <= in_valid & n_flg[1];
      flg_overflow  <= in_valid & n_flg[2];
      flg_underflow <= in_valid & n_flg[3];
      flg_inexact   <= in_valid & n_flg[4];
      if (in_valid) result <= n_res;
    end
  end
endmodule

// File: rtl/recip_est_chk.sv
module recip_est_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] operand,
  input logic        fixed_mode,
  input logic        ftz,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        flg_invalid,
  input logic        flg_divzero,
  input logic        flg_overflow,
  input logic        flg_underflow,
  input logic        flg_inexact
);
  wire [4:0] flags = {flg_inexact, flg_underflow, flg_overflow, flg_divzero, flg_invalid};
  wire       flt   = in_valid && !fixed_mode;

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid latency"); // R1
  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (flags == 5'd0)) else $error("flags while idle"); // R1
  AST_FIXED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fixed_mode && !operand[31]) |=> (result == 32'hFFFFFFFF && flags == 5'd0))
    else $error("fixed negative"); // R3
  AST_ZERO_DZ: assert property (@(posedge clk) disable iff (!rst_n)
    (flt && operand[30:0] == 31'd0) |=> (flags == 5'b00010 && result[30:0] == 31'h7F800000))
    else $error("zero input"); // R5
  AST_INF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flt && operand[30:0] == 31'h7F800000) |=> (flags == 5'd0 && result[30:0] == 31'd0))
    else $error("inf input"); // R5
  AST_TINY_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (flt && !ftz && operand[30:23] == 8'd0 && operand[22:0] != 23'd0 && operand[22:21] == 2'b00)
    |=> (flg_overflow && flg_inexact)) else $error("tiny overflow"); // R6
  AST_FTZ_UNF: assert property (@(posedge clk) disable iff (!rst_n)
    (flt && ftz && (operand[30:23] == 8'd253 || operand[30:23] == 8'd254))
    |=> (flg_underflow && result[30:0] == 31'd0)) else $error("flush underflow"); // R7
endmodule

bind recip_est recip_est_chk chk_i (.*);

// File: tb/recip_est_tb.sv
`timescale 1ns/1ps
module recip_est_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, fixed_mode, ftz, dnan;
  logic [31:0] operand;
  logic [1:0]  rmode;
  logic        out_valid;
  logic [31:0] result;
  logic        flg_invalid, flg_divzero, flg_overflow, flg_underflow, flg_inexact;
  int n_chk = 0;
  int n_bad = 0;

  recip_est dut_i (.*);

  function automatic logic [8:0] ref_est(input logic [8:0] x);
    int q;
    q = 524288 / (2 * int'(x) + 1);
    return 9'((q + 1) / 2);
  endfunction

  function automatic logic [36:0] model(input logic [31:0] op, input logic fx,
                                        input logic [1:0] rm, input logic fz, input logic dn);
    logic s; logic [7:0] e; logic [22:0] f, m; logic [4:0] fl; logic [31:0] r;
    logic [8:0] est; logic [23:0] mant; int ee, rx; logic up;
    s = op[31]; e = op[30:23]; f = op[22:0]; fl = 5'd0;
    if (fx) r = op[31] ? {ref_est(op[31:23]), 23'd0} : 32'hFFFFFFFF;
    else if (e == 8'd255 && f != 0) begin
      fl[0] = !f[22]; r = dn ? 32'h7FC00000 : (op | 32'h00400000);
    end else if (e == 8'd255) r = {s, 31'd0};
    else if (e == 8'd0 && (f == 0 || fz)) begin fl[1] = 1'b1; r = {s, 8'hFF, 23'd0}; end
    else if (e == 8'd0 && f < 23'h200000) begin
      fl[2] = 1'b1; fl[4] = 1'b1;
      up = (rm == 2'd0) || (rm == 2'd1 && !s) || (rm == 2'd2 && s);
      r = up ? {s, 8'hFF, 23'd0} : {s, 31'h7F7FFFFF};
    end else if (fz && e >= 8'd253) begin fl[3] = 1'b1; r = {s, 31'd0}; end
    else begin
      ee = int'(e); m = f;
      if (e == 8'd0) begin
        while (!m[22]) begin m = m << 1; ee = ee - 1; end
        m = m << 1;
      end
      rx = 253 - ee;
      est = ref_est({1'b1, m[22:15]});
      mant = {1'b1, est[7:0], 15'd0};
      if (rx > 0) r = {s, 8'(rx), mant[22:0]};
      else begin mant = mant >> (1 - rx); r = {s, 8'd0, mant[22:0]}; end
    end
    return {fl, r};
  endfunction

  logic [36:0] exp_v;

  task automatic run(input logic [31:0] op, input logic fx, input logic [1:0] rm,
                     input logic fz, input logic dn, input string req);
    logic [36:0] got;
    operand = op; fixed_mode = fx; rmode = rm; ftz = fz; dnan = dn; in_valid = 1'b1;
    exp_v = model(op, fx, rm, fz, dn);
    @(negedge clk);
    got = {flg_inexact, flg_underflow, flg_overflow, flg_divzero, flg_invalid, result};
    n_chk++;
    if (!out_valid || got != exp_v) begin
      n_bad++;
      $display("FAIL %s op=%h valid=%b got=%h expected=%h", req, op, out_valid, got, exp_v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = 32'd0; fixed_mode = 1'b0;
    rmode = 2'd0; ftz = 1'b0; dnan = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid || result != 0 || flg_invalid || flg_divzero || flg_overflow || flg_underflow || flg_inexact) begin
      n_bad++; $display("FAIL R1 reset state: valid=%b result=%h expected 0", out_valid, result);
    end
    for (int i = 0; i < 512; i++)
      run({i[8:0], 23'(i * 12345)}, 1'b1, 2'(i), i[0], i[1], i[8] ? "R2" : "R3");
    for (int e = 1; e < 255; e++) begin
      run({e[0], 8'(e), 8'(e * 37), 15'(e * 101)}, 1'b0, 2'(e), 1'b0, 1'b0, "R9");
      run({e[1], 8'(e), 8'(e * 91), 15'(e * 7)}, 1'b0, 2'(e + 1), 1'b1, 1'b0, "R7");
    end
    run(32'h7F800001, 1'b0, 2'd0, 1'b0, 1'b0, "R4");
    run(32'hFFA00000, 1'b0, 2'd0, 1'b0, 1'b0, "R4");
    run(32'h7FC12345, 1'b0, 2'd0, 1'b0, 1'b0, "R4");
    run(32'hFF812345, 1'b0, 2'd0, 1'b0, 1'b1, "R4");
    run(32'h7FE00000, 1'b0, 2'd0, 1'b0, 1'b1, "R4");
    run(32'h7F800000, 1'b0, 2'd0, 1'b0, 1'b0, "R5");
    run(32'hFF800000, 1'b0, 2'd0, 1'b0, 1'b0, "R5");
    run(32'h00000000, 1'b0, 2'd0, 1'b0, 1'b0, "R5");
    run(32'h80000000, 1'b0, 2'd0, 1'b0, 1'b0, "R5");
    for (int k = 0; k < 8; k++)
      run({k[2], 8'd0, 23'h1FFFFF >> k}, 1'b0, 2'(k), 1'b0, 1'b0, "R6");
    run(32'h00000001, 1'b0, 2'd3, 1'b0, 1'b0, "R6");
    run(32'h00400000, 1'b0, 2'd0, 1'b1, 1'b0, "R8");
    run(32'h80612345, 1'b0, 2'd0, 1'b1, 1'b0, "R8");
    run(32'h00012345, 1'b0, 2'd0, 1'b1, 1'b0, "R8");
    for (int k = 0; k < 16; k++) begin
      run({k[0], 8'd0, 1'b1, 22'(k * 98765)}, 1'b0, 2'd0, 1'b0, 1'b0, "R11");
      run({k[1], 8'd0, 2'b01, 21'(k * 54321)}, 1'b0, 2'd1, 1'b0, 1'b0, "R11");
      run({k[0], 8'd253, 23'(k * 524287)}, 1'b0, 2'd2, 1'b0, 1'b0, "R10");
      run({k[1], 8'd254, 23'(k * 300001)}, 1'b0, 2'd3, 1'b0, 1'b0, "R10");
    end
    in_valid = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid || flg_invalid || flg_divzero || flg_overflow || flg_underflow || flg_inexact) begin
      n_bad++; $display("FAIL R1 idle: valid=%b expected 0", out_valid);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule